// File: doc/BRIEF.md
# Seconds and Ticks Time Base with Event Tags

This block keeps the running time of a system as two 32-bit words: a seconds count and a sub-second tick count that advances once per system-clock cycle. With the default setting of 125,000,000 ticks per second it follows a 125 MHz clock, so the tick word covers one second in steps of 8 ns and then rolls back to zero while the seconds word steps up by one.

Host software sets the time by loading a new seconds value. The load also zeroes the tick word, so counting restarts at the start of the loaded second. A set of event strobes, each one clock cycle wide, freezes the current time into one capture register per event. The default build has three channels: the trigger (strobed when the already-delayed trigger fires), acquisition start and acquisition stop. Each capture takes both words from the same cycle, so the tag never mixes an old seconds value with a new tick value.

Top module: `ts_timebase`

## Requirements
- R1: While reset is high and on the first sampling after it, `now_sec`, `now_tick` and every tag word read zero.
- R2: With no load, `now_tick` rises by exactly one each clock cycle while it is below TICKS_PER_SEC-1.
- R3: When `now_tick` equals TICKS_PER_SEC-1 and no load is requested, the next cycle shows tick 0 and `now_sec` one higher. The tick word never reaches TICKS_PER_SEC.
- R4: A cycle with `set_valid` high makes the next cycle show `now_sec` equal to `set_sec` and `now_tick` equal to 0.
- R5: A load requested on the same cycle as a tick rollover wins: the seconds word takes `set_sec` and does not also step up.
- R6: When bit i of `evt_strobe` is high in a cycle, from the next cycle the tag slice i (`tag_sec[32*i +: 32]`, `tag_tick[32*i +: 32]`) holds the `now_sec`/`now_tick` values shown during the strobe cycle. Bit 0 is trigger, bit 1 is start and bit 2 is stop.
- R7: A strobe on the last tick of a second captures the old seconds value together with tick TICKS_PER_SEC-1, never a torn mix of the two words.
- R8: A tag slice whose strobe bit is low keeps its value unchanged.
- R9: Several strobe bits high in the same cycle all capture the same time.
- R10: A strobe on the same cycle as a load captures the time from before the load.
- R11: The seconds word wraps from 0xFFFFFFFF to 0 on rollover.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| set_valid | input | 1 | One-cycle request to load the seconds word |
| set_sec | input | 32 | Seconds value to load |
| evt_strobe | input | 3 | One-cycle event strobes: bit 0 trigger, bit 1 start, bit 2 stop |
| now_sec | output | 32 | Current seconds word |
| now_tick | output | 32 | Current tick word, 0 to TICKS_PER_SEC-1 |
| tag_sec | output | 96 | Captured seconds, 32 bits per event |
| tag_tick | output | 96 | Captured ticks, 32 bits per event |

## Verification
The bench runs a ten-tick second so that every tick position can be reached. It loads the time at every position, which includes the rollover cycle where a design that let the increment win would show a seconds value one too high. It strobes each channel at every tick, so a design that took the two words from different cycles would tear the tag at the last tick, and a capture off by one cycle would miss on every strobe. Seconds wrap-around, simultaneous strobes and a strobe during a load are also covered, since a design that captured after the load would tag the new time.

// File: rtl/ts_pkg.sv
package ts_pkg;
  // Event channel indices into evt_strobe and the tag buses
  localparam int EV_TRIG  = 0;
  localparam int EV_START = 1;
  localparam int EV_STOP  = 2;
  localparam int NUM_EV   = 3;
  localparam int WORD_W   = 32;
endpackage

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter int SEC_W         = 32,
  parameter int TICK_W        = 32,
  parameter int TICKS_PER_SEC = 125_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_valid,
  input  logic [SEC_W-1:0]  set_sec,
  output logic [SEC_W-1:0]  sec_q,
  output logic [TICK_W-1:0] tick_q
);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS_PER_SEC - 1);

  logic at_last;
  assign at_last = (tick_q == LAST_TICK);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= '0;
      tick_q <= '0;
    end else if (set_valid) begin
      sec_q  <= set_sec;
      tick_q <= '0;
    end else if (at_last) begin
      sec_q  <= sec_q + 1'b1;
      tick_q <= '0;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  // R2: plain step
  a_r2_tick_step: assert property (@(posedge clk) disable iff (rst)
    (!set_valid && tick_q != LAST_TICK) |=> (tick_q == $past(tick_q) + 1'b1) && $stable(sec_q));
  // R3: rollover
  a_r3_rollover: assert property (@(posedge clk) disable iff (rst)
    (!set_valid && tick_q == LAST_TICK) |=> (tick_q == '0) && (sec_q == $past(sec_q) + 1'b1));
  a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
    tick_q < TICK_W'(TICKS_PER_SEC));
  // R4, R5: load wins over everything
  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    set_valid |=> (tick_q == '0) && (sec_q == $past(set_sec)));
endmodule

// File: rtl/ts_capture.sv
module ts_capture #(
  parameter int SEC_W  = 32,
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [TICK_W-1:0] cur_tick,
  output logic [SEC_W-1:0]  tag_sec,
  output logic [TICK_W-1:0] tag_tick
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_sec  <= '0;
      tag_tick <= '0;
    end else if (strobe) begin
      tag_sec  <= cur_sec;
      tag_tick <= cur_tick;
    end
  end

  // R6, R7: both words from the strobe cycle
  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (tag_sec == $past(cur_sec)) && (tag_tick == $past(cur_tick)));
  // R8: hold
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(tag_sec) && $stable(tag_tick));
endmodule

// File: rtl/ts_timebase.sv
module ts_timebase
  import ts_pkg::*;
#(
  parameter int SEC_W         = WORD_W,
  parameter int TICK_W        = WORD_W,
  parameter int TICKS_PER_SEC = 125_000_000,
  parameter int N_EVT         = NUM_EV
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    set_valid,
  input  logic [SEC_W-1:0]        set_sec,
  input  logic [N_EVT-1:0]        evt_strobe,
  output logic [SEC_W-1:0]        now_sec,
  output logic [TICK_W-1:0]       now_tick,
  output logic [N_EVT*SEC_W-1:0]  tag_sec,
  output logic [N_EVT*TICK_W-1:0] tag_tick
);
  ts_counter #(
    .SEC_W(SEC_W), .TICK_W(TICK_W), .TICKS_PER_SEC(TICKS_PER_SEC)
  ) u_cnt (
    .clk(clk), .rst(rst), .set_valid(set_valid), .set_sec(set_sec),
    .sec_q(now_sec), .tick_q(now_tick)
  );

  for (genvar i = 0; i < N_EVT; i++) begin : g_cap
    ts_capture #(.SEC_W(SEC_W), .TICK_W(TICK_W)) u_cap (
      .clk(clk), .rst(rst), .strobe(evt_strobe[i]),
      .cur_sec(now_sec), .cur_tick(now_tick),
      .tag_sec(tag_sec[i*SEC_W +: SEC_W]),
      .tag_tick(tag_tick[i*TICK_W +: TICK_W])
    );
  end

  // R9: strobes in one cycle yield equal tags for the first two channels
  if (N_EVT > 1) begin : g_same
    a_r9_same_time: assert property (@(posedge clk) disable iff (rst)
      (evt_strobe[0] && evt_strobe[1]) |=>
        (tag_sec[0 +: SEC_W] == tag_sec[SEC_W +: SEC_W]) &&
        (tag_tick[0 +: TICK_W] == tag_tick[TICK_W +: TICK_W]));
  end
endmodule

// File: tb/ts_timebase_tb.sv
module ts_timebase_tb;
  localparam int TPS = 10;
  localparam int NE  = 3;

  logic clk = 0;
  logic rst = 1;
  logic set_valid = 0;
  logic [31:0] set_sec = '0;
  logic [NE-1:0] evt_strobe = '0;
  logic [31:0] now_sec, now_tick;
  logic [NE*32-1:0] tag_sec, tag_tick;

  int n_run = 0;
  int n_fail = 0;

  // arithmetic model: time = base seconds + elapsed cycles since last load
  longint unsigned elapsed = 0;
  logic [31:0] base = '0;
  logic [31:0] m_sec [NE];
  logic [31:0] m_tick[NE];

  always #10 clk = ~clk;

  ts_timebase #(.TICKS_PER_SEC(TPS), .N_EVT(NE)) u_dut (
    .clk(clk), .rst(rst), .set_valid(set_valid), .set_sec(set_sec),
    .evt_strobe(evt_strobe), .now_sec(now_sec), .now_tick(now_tick),
    .tag_sec(tag_sec), .tag_tick(tag_tick)
  );

  function automatic logic [31:0] e_tick();
    return 32'(elapsed % TPS);
  endfunction
  function automatic logic [31:0] e_sec();
    return base + 32'(elapsed / TPS);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string lc, input string lt);
    chk(now_sec  == e_sec(),  {lc, " sec"},  now_sec,  e_sec());
    chk(now_tick == e_tick(), {lc, " tick"}, now_tick, e_tick());
    for (int i = 0; i < NE; i++) begin
      chk(tag_sec[i*32 +: 32]  == m_sec[i],  {lt, " tag sec"},  tag_sec[i*32 +: 32],  m_sec[i]);
      chk(tag_tick[i*32 +: 32] == m_tick[i], {lt, " tag tick"}, tag_tick[i*32 +: 32], m_tick[i]);
    end
  endtask

  task automatic step(input string lc, input string lt);
    @(posedge clk);
    for (int i = 0; i < NE; i++)
      if (evt_strobe[i]) begin
        m_sec[i]  = e_sec();
        m_tick[i] = e_tick();
      end
    if (set_valid) begin
      base = set_sec;
      elapsed = 0;
    end else begin
      elapsed++;
    end
    @(negedge clk);
    check_all(lc, lt);
    set_valid = 0;
    evt_strobe = '0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_sec[i] = '0;
      m_tick[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1", "R1");
    rst = 0;

    // free run across several seconds
    for (int k = 0; k < 3*TPS + 3; k++) step("R2 R3", "R8");

    // load at every tick position; last position collides with rollover
    for (int p = 0; p < TPS; p++) begin
      while (e_tick() != 32'(p)) step("R2 R3", "R8");
      set_valid = 1;
      set_sec = 32'(1000 + p);
      step((p == TPS-1) ? "R5" : "R4", "R8");
      step("R4", "R8");
    end

    // seconds wrap
    set_valid = 1;
    set_sec = 32'hFFFF_FFFF;
    step("R4", "R8");
    for (int k = 0; k < TPS + 2; k++) step("R11", "R8");

    // capture on each channel at every tick position
    for (int c = 0; c < NE; c++)
      for (int p = 0; p < TPS; p++) begin
        while (e_tick() != 32'(p)) step("R2 R3", "R8");
        evt_strobe[c] = 1'b1;
        step("R2 R3", (p == TPS-1) ? "R7" : "R6");
      end

    // all channels together
    evt_strobe = '1;
    step("R2 R3", "R9");

    // strobe together with a load
    set_valid = 1;
    set_sec = 32'h0000_1234;
    evt_strobe = 3'b101;
    step("R4", "R10");

    // hold
    for (int k = 0; k < 2*TPS; k++) step("R2 R3", "R8");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule